// File: doc/BRIEF.md
# Direct-Mapped Backup Cache Tag Controller

This block holds the tag store of a physically addressed, direct-mapped backup cache whose lines are 32 bytes long. A cache pipeline presents 32-bit physical addresses on a lookup port and gets back hit and owned indications two cycles later. A fill port writes a new tag together with its valid and owned bits when a line is brought in or its state changes.

A third port serves internal processor register accesses. It recognises two address windows with a 0x20 stride between consecutive entries. The first window, based at 0x01000000, reads or overwrites tag entries directly. The second, based at 0x01400000, deallocates lines: a write there invalidates the entry and reports whether the line held owned data that must be written back. The window length follows the configured entry count. Any other register address is acknowledged, flagged as unimplemented and has no effect.

The cache size parameter (128, 512 or 2048 KB) moves the boundary between tag and index inside the address. The tag and index widths, the RAM depth and the window decode all follow from it.

Top module: `cache_tag_ctrl`

## Requirements
- R1: With CACHE_KB = 128 the index is address bits 16:5 and the tag is bits 28:17. With 512 they are bits 18:5 and 28:19, and with 2048 they are bits 20:5 and 28:21. Address bits 31:29 and 4:0 do not affect a lookup.
- R2: A lookup hits only when the entry's valid bit is set and its stored tag equals the tag field of the address.
- R3: A lookup accepted at a clock edge (lk_valid and lk_ready high) produces a one-cycle lk_done pulse, together with lk_hit and lk_owned, after the following edge.
- R4: A fill (fill_en and fill_ready high) writes the address tag, fill_valid and fill_owned into the indexed entry. Later lookups see the new values.
- R5: lk_owned is high only on a hit whose entry has its owned bit set. A register read reports the owned bit (bit 30) only when the entry is valid.
- R6: In the tag window, base 0x01000000, stride 0x20, 2^index-width entries, index = address bits (index width + 4):5, a register read returns bit 31 = valid, bit 30 = owned and the stored tag in bits (tag width − 1):0. All other bits are zero.
- R7: A register write in the tag window overwrites the entry. Bit 31 becomes valid, bit 30 becomes owned and the low tag-width bits become the tag.
- R8: A register write in the deallocate window (base 0x01400000, same stride and length) clears the entry's valid and owned state and keeps the stored tag. rg_wb is raised with the acknowledge when the entry was valid and owned beforehand.
- R9: A register read in the deallocate window is acknowledged with data zero and changes nothing.
- R10: A register access outside both windows, including one past the configured entry count, is acknowledged with rg_unimpl high and data zero. It changes no entry.
- R11: Only one operation is accepted per cycle. Register access ranks above fill, and fill ranks above lookup. While rg_req is high, fill_ready and lk_ready are low. While fill_en is high, lk_ready is low.
- R12: Reset invalidates every entry and clears lk_done, rg_ack and the other outputs.
- R13: A register request is always accepted. rg_ack, with rg_rdata, rg_unimpl and rg_wb, appears after the edge following the one that accepted it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request, held until accepted |
| lk_addr | input | 32 | Lookup physical address |
| lk_ready | output | 1 | Lookup accepted this cycle when high with lk_valid |
| lk_done | output | 1 | Lookup result strobe |
| lk_hit | output | 1 | Lookup hit |
| lk_owned | output | 1 | Hit entry is owned |
| fill_en | input | 1 | Fill request, held until accepted |
| fill_addr | input | 32 | Fill physical address |
| fill_valid | input | 1 | Valid bit to store |
| fill_owned | input | 1 | Owned bit to store |
| fill_ready | output | 1 | Fill accepted this cycle when high with fill_en |
| rg_req | input | 1 | Register access request, one cycle |
| rg_we | input | 1 | Register write when high, read when low |
| rg_addr | input | 32 | Register address |
| rg_wdata | input | 32 | Register write data |
| rg_ack | output | 1 | Register access completed |
| rg_rdata | output | 32 | Register read data |
| rg_unimpl | output | 1 | Access hit no implemented register |
| rg_wb | output | 1 | Deallocated line needs writeback |

## Verification
The properties take for granted that CACHE_KB is one of the three legal sizes. They also assume that every control input is known from the first edge after reset and that a register request lasts a single cycle per access. Lookup and fill requesters are assumed to hold their request until the matching ready is seen. The stimulus drives every input on the falling edge and keeps rg_req to one-cycle pulses. It issues one operation at a time, except in the arbitration tests, where it deliberately collides a register access with a lookup and with a fill and then holds the loser until it is accepted.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_LOOK,
    OP_FILL,
    OP_TRD,
    OP_TWR,
    OP_DRD,
    OP_DWR,
    OP_BAD
  } cbt_op_e;

  localparam logic [31:0] TAG_WIN_BASE = 32'h0100_0000;
  localparam logic [31:0] DEL_WIN_BASE = 32'h0140_0000;
  localparam int          LINE_LSB     = 5;
  localparam int          PA_TOP       = 28;

  function automatic int idx_bits(input int size_kb);
    if (size_kb >= 2048)     return 16;
    else if (size_kb >= 512) return 14;
    else                     return 12;
  endfunction

endpackage

// File: rtl/cbt_reg_decode.sv
module cbt_reg_decode #(
  parameter int IDX_W = 12,
  localparam int HI_W = 32 - IDX_W - cbt_pkg::LINE_LSB
) (
  input  logic [HI_W-1:0] addr_hi,
  output logic            in_tag_win,
  output logic            in_del_win
);
  localparam int SLO = IDX_W + cbt_pkg::LINE_LSB;
  localparam logic [HI_W-1:0] TAG_HI = cbt_pkg::TAG_WIN_BASE[31:SLO];
  localparam logic [HI_W-1:0] DEL_HI = cbt_pkg::DEL_WIN_BASE[31:SLO];

  always_comb begin
    in_tag_win = (addr_hi == TAG_HI);
    in_del_win = (addr_hi == DEL_HI);
  end
endmodule

// File: rtl/cbt_valid_array.sv
module cbt_valid_array #(
  parameter int IDX_W = 12,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic             wr,
  input  logic             wval,
  output logic             rd
);
  logic [ENTRIES-1:0] vbits;

  always_ff @(posedge clk) begin
    if (rst)     vbits <= '0;
    else if (wr) vbits[idx] <= wval;
  end

  assign rd = vbits[idx];
endmodule

// File: rtl/cbt_tag_ram.sv
module cbt_tag_ram #(
  parameter int IDX_W = 12,
  parameter int DW    = 13,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] addr,
  input  logic             we,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    q
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    q <= mem[addr];
  end
endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl #(
  parameter int CACHE_KB = 128
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        lk_valid,
  input  logic [31:0] lk_addr,
  output logic        lk_ready,
  output logic        lk_done,
  output logic        lk_hit,
  output logic        lk_owned,
  input  logic        fill_en,
  input  logic [31:0] fill_addr,
  input  logic        fill_valid,
  input  logic        fill_owned,
  output logic        fill_ready,
  input  logic        rg_req,
  input  logic        rg_we,
  input  logic [31:0] rg_addr,
  input  logic [31:0] rg_wdata,
  output logic        rg_ack,
  output logic [31:0] rg_rdata,
  output logic        rg_unimpl,
  output logic        rg_wb
);
  import cbt_pkg::*;

  localparam int IDX_W   = idx_bits(CACHE_KB);
  localparam int TAG_LSB = IDX_W + LINE_LSB;
  localparam int TAG_W   = PA_TOP - TAG_LSB + 1;
  localparam int ENT_W   = TAG_W + 1;

  // stage 0: arbitration and RAM/valid access
  logic             in_tag_win, in_del_win;
  cbt_op_e          op0;
  logic [IDX_W-1:0] idx0;
  logic [TAG_W-1:0] tag0;
  logic             ram_we, v_we, v_val;
  logic [ENT_W-1:0] ram_wd, ram_q;
  logic             v_rd;

  cbt_reg_decode #(.IDX_W(IDX_W)) u_dec (
    .addr_hi    (rg_addr[31:TAG_LSB]),
    .in_tag_win (in_tag_win),
    .in_del_win (in_del_win)
  );

  assign fill_ready = !rg_req;
  assign lk_ready   = !rg_req && !fill_en;

  always_comb begin
    op0    = OP_NONE;
    idx0   = lk_addr[TAG_LSB-1:LINE_LSB];
    tag0   = lk_addr[PA_TOP:TAG_LSB];
    ram_we = 1'b0;
    ram_wd = '0;
    v_we   = 1'b0;
    v_val  = 1'b0;
    if (rg_req) begin
      idx0 = rg_addr[TAG_LSB-1:LINE_LSB];
      if (in_tag_win) begin
        op0 = rg_we ? OP_TWR : OP_TRD;
        if (rg_we) begin
          ram_we = 1'b1;
          ram_wd = {rg_wdata[30], rg_wdata[TAG_W-1:0]};
          v_we   = 1'b1;
          v_val  = rg_wdata[31];
        end
      end else if (in_del_win) begin
        op0 = rg_we ? OP_DWR : OP_DRD;
        if (rg_we) begin
          v_we  = 1'b1;
          v_val = 1'b0;
        end
      end else begin
        op0 = OP_BAD;
      end
    end else if (fill_en) begin
      op0    = OP_FILL;
      idx0   = fill_addr[TAG_LSB-1:LINE_LSB];
      ram_we = 1'b1;
      ram_wd = {fill_owned, fill_addr[PA_TOP:TAG_LSB]};
      v_we   = 1'b1;
      v_val  = fill_valid;
    end else if (lk_valid) begin
      op0 = OP_LOOK;
    end
  end

  cbt_tag_ram #(.IDX_W(IDX_W), .DW(ENT_W)) u_ram (
    .clk   (clk),
    .addr  (idx0),
    .we    (ram_we),
    .wdata (ram_wd),
    .q     (ram_q)
  );

  cbt_valid_array #(.IDX_W(IDX_W)) u_vld (
    .clk  (clk),
    .rst  (rst),
    .idx  (idx0),
    .wr   (v_we),
    .wval (v_val),
    .rd   (v_rd)
  );

  // stage 1: registered op context aligned with RAM output
  cbt_op_e          s1_op;
  logic [TAG_W-1:0] s1_tag;
  logic             s1_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_op  <= OP_NONE;
      s1_tag <= '0;
      s1_vld <= 1'b0;
    end else begin
      s1_op  <= op0;
      s1_tag <= tag0;
      s1_vld <= v_rd;
    end
  end

  logic [TAG_W-1:0] q_tag;
  logic             q_own, s1_match, s1_is_reg;
  logic [31:0]      rd_word;

  always_comb begin
    q_tag     = ram_q[TAG_W-1:0];
    q_own     = ram_q[TAG_W];
    s1_match  = s1_vld && (q_tag == s1_tag);
    s1_is_reg = (s1_op == OP_TRD) || (s1_op == OP_TWR) || (s1_op == OP_DRD) ||
                (s1_op == OP_DWR) || (s1_op == OP_BAD);
    rd_word   = '0;
    if (s1_op == OP_TRD) begin
      rd_word[31]        = s1_vld;
      rd_word[30]        = s1_vld && q_own;
      rd_word[TAG_W-1:0] = q_tag;
    end
  end

  // stage 2: registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      lk_done   <= 1'b0;
      lk_hit    <= 1'b0;
      lk_owned  <= 1'b0;
      rg_ack    <= 1'b0;
      rg_rdata  <= '0;
      rg_unimpl <= 1'b0;
      rg_wb     <= 1'b0;
    end else begin
      lk_done   <= (s1_op == OP_LOOK);
      lk_hit    <= (s1_op == OP_LOOK) && s1_match;
      lk_owned  <= (s1_op == OP_LOOK) && s1_match && q_own;
      rg_ack    <= s1_is_reg;
      rg_rdata  <= rd_word;
      rg_unimpl <= (s1_op == OP_BAD);
      rg_wb     <= (s1_op == OP_DWR) && s1_vld && q_own;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{lk_addr[31:29], lk_addr[4:0], fill_addr[31:29],
                         fill_addr[4:0], rg_addr[4:0], rg_wdata[29:TAG_W]};
endmodule

// File: rtl/cache_tag_ctrl_chk.sv
module cache_tag_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic lk_valid,
  input logic lk_ready,
  input logic fill_en,
  input logic fill_ready,
  input logic rg_req,
  input logic lk_done,
  input logic lk_hit,
  input logic lk_owned,
  input logic rg_ack,
  input logic rg_unimpl,
  input logic rg_wb
);
  // R11
  reg_blocks_others_chk: assert property (@(posedge clk) disable iff (rst)
    rg_req |-> (!lk_ready && !fill_ready));
  // R11
  fill_blocks_look_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_en && lk_valid) |-> !lk_ready);
  // R3
  look_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_ready) |=> ##1 lk_done);
  // R13
  reg_latency_chk: assert property (@(posedge clk) disable iff (rst)
    rg_req |=> ##1 rg_ack);
  // R5
  owned_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
    lk_owned |-> (lk_hit && lk_done));
  // R2
  hit_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> lk_done);
  // R10
  unimpl_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
    rg_unimpl |-> (rg_ack && !rg_wb));
  // R8
  wb_needs_ack_chk: assert property (@(posedge clk) disable iff (rst)
    rg_wb |-> rg_ack);
  // R12
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!lk_done && !rg_ack));
endmodule

bind cache_tag_ctrl cache_tag_ctrl_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .lk_valid   (lk_valid),
  .lk_ready   (lk_ready),
  .fill_en    (fill_en),
  .fill_ready (fill_ready),
  .rg_req     (rg_req),
  .lk_done    (lk_done),
  .lk_hit     (lk_hit),
  .lk_owned   (lk_owned),
  .rg_ack     (rg_ack),
  .rg_unimpl  (rg_unimpl),
  .rg_wb      (rg_wb)
);

// File: tb/sim_cache_tag_ctrl.sv
module sim_cache_tag_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        lk_ready, lk_done, lk_hit, lk_owned;
  logic        fill_en = 1'b0;
  logic [31:0] fill_addr = '0;
  logic        fill_valid = 1'b0, fill_owned = 1'b0;
  logic        fill_ready;
  logic        rg_req = 1'b0, rg_we = 1'b0;
  logic [31:0] rg_addr = '0, rg_wdata = '0;
  logic        rg_ack, rg_unimpl, rg_wb;
  logic [31:0] rg_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cache_tag_ctrl #(.CACHE_KB(128)) u0 (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_ready(lk_ready),
    .lk_done(lk_done), .lk_hit(lk_hit), .lk_owned(lk_owned),
    .fill_en(fill_en), .fill_addr(fill_addr), .fill_valid(fill_valid),
    .fill_owned(fill_owned), .fill_ready(fill_ready),
    .rg_req(rg_req), .rg_we(rg_we), .rg_addr(rg_addr), .rg_wdata(rg_wdata),
    .rg_ack(rg_ack), .rg_rdata(rg_rdata), .rg_unimpl(rg_unimpl), .rg_wb(rg_wb)
  );

  // {req[3:0], op[1:0], addr, wdata, exp_rdata, exp_hit, exp_own, exp_wb, exp_un}
  // op: 0 fill (wdata bit0 valid, bit1 owned), 1 lookup, 2 reg write, 3 reg read
  localparam int NV = 27;
  localparam logic [105:0] VEC [NV] = '{
    {4'd12, 2'd1, 32'h0000_0040, 32'h0, 32'h0,          4'b0000}, // R12 empty
    {4'd4,  2'd0, 32'h0002_0040, 32'h1, 32'h0,          4'b0000}, // R4 fill
    {4'd4,  2'd1, 32'h0002_0040, 32'h0, 32'h0,          4'b1000}, // R4
    {4'd1,  2'd1, 32'hE002_005F, 32'h0, 32'h0,          4'b1000}, // R1 ignored bits
    {4'd2,  2'd1, 32'h0004_0040, 32'h0, 32'h0,          4'b0000}, // R2 tag differs
    {4'd4,  2'd0, 32'h1FFE_0060, 32'h3, 32'h0,          4'b0000}, // R4 fill owned
    {4'd5,  2'd1, 32'h1FFE_0060, 32'h0, 32'h0,          4'b1100}, // R5
    {4'd6,  2'd3, 32'h0100_0060, 32'h0, 32'hC000_0FFF,  4'b0000}, // R6
    {4'd6,  2'd3, 32'h0100_0040, 32'h0, 32'h8000_0001,  4'b0000}, // R6
    {4'd7,  2'd2, 32'h0100_0080, 32'h8000_0ABC, 32'h0,  4'b0000}, // R7
    {4'd7,  2'd1, 32'h1578_0080, 32'h0, 32'h0,          4'b1000}, // R7
    {4'd8,  2'd2, 32'h0140_0060, 32'h0, 32'h0,          4'b0010}, // R8 wb
    {4'd8,  2'd1, 32'h1FFE_0060, 32'h0, 32'h0,          4'b0000}, // R8
    {4'd8,  2'd3, 32'h0100_0060, 32'h0, 32'h0000_0FFF,  4'b0000}, // R8 tag kept
    {4'd8,  2'd2, 32'h0140_0040, 32'h0, 32'h0,          4'b0000}, // R8 no wb
    {4'd8,  2'd1, 32'h0002_0040, 32'h0, 32'h0,          4'b0000}, // R8
    {4'd9,  2'd3, 32'h0140_0080, 32'h0, 32'h0,          4'b0000}, // R9
    {4'd9,  2'd1, 32'h1578_0080, 32'h0, 32'h0,          4'b1000}, // R9
    {4'd10, 2'd2, 32'h0102_0000, 32'hC000_0777, 32'h0,  4'b0001}, // R10 past end
    {4'd10, 2'd3, 32'h0100_0000, 32'h0, 32'h0,          4'b0000}, // R10
    {4'd10, 2'd3, 32'h0200_0000, 32'h0, 32'h0,          4'b0001}, // R10 outside
    {4'd10, 2'd2, 32'h0142_0080, 32'h0, 32'h0,          4'b0001}, // R10
    {4'd10, 2'd1, 32'h1578_0080, 32'h0, 32'h0,          4'b1000}, // R10
    {4'd6,  2'd3, 32'h0101_FFE0, 32'h0, 32'h0,          4'b0000}, // R6 last entry
    {4'd7,  2'd2, 32'h0101_FFE0, 32'h4000_0123, 32'h0,  4'b0000}, // R7
    {4'd2,  2'd1, 32'h0247_FFE0, 32'h0, 32'h0,          4'b0000}, // R2 invalid
    {4'd5,  2'd3, 32'h0101_FFE0, 32'h0, 32'h0000_0123,  4'b0000}  // R5 mask
  };

  task automatic chk(input int req, input logic [63:0] act, input logic [63:0] exp,
                     input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    case (op)
      2'd0: begin fill_en = 1'b1; fill_addr = a; fill_valid = d[0]; fill_owned = d[1]; end
      2'd1: begin lk_valid = 1'b1; lk_addr = a; end
      default: begin rg_req = 1'b1; rg_we = (op == 2'd2); rg_addr = a; rg_wdata = d; end
    endcase
    @(negedge clk);
    fill_en = 1'b0; lk_valid = 1'b0; rg_req = 1'b0; rg_we = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R3 watchdog expired: actual running expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 outputs quiet under reset
    chk(12, {58'd0, lk_done, lk_hit, lk_owned, rg_ack, rg_unimpl, rg_wb}, 64'd0, "reset outputs");
    rst = 1'b0;
    @(negedge clk);
    chk(11, {62'd0, lk_ready, fill_ready}, 64'd3, "idle ready");

    for (int i = 0; i < NV; i++) begin
      logic [105:0] v;
      v = VEC[i];
      drive_op(v[101:100], v[99:68], v[67:36]);
      if (v[101:100] == 2'd1)
        chk(int'(v[105:102]), {61'd0, lk_done, lk_hit, lk_owned},
            {61'd0, 1'b1, v[3], v[2]}, $sformatf("lookup vec %0d", i));
      else if (v[101:100] != 2'd0)
        chk(int'(v[105:102]), {29'd0, rg_ack, rg_unimpl, rg_wb, rg_rdata},
            {29'd0, 1'b1, v[0], v[1], v[35:4]}, $sformatf("register vec %0d", i));
    end

    // R11 register access beats a lookup, lookup stalls one cycle
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = 32'h1578_0080;
    rg_req = 1'b1; rg_we = 1'b0; rg_addr = 32'h0100_0080;
    #1 chk(11, {63'd0, lk_ready}, 64'd0, "lookup stalled by register");
    @(negedge clk);
    rg_req = 1'b0;
    #1 chk(11, {63'd0, lk_ready}, 64'd1, "lookup released");
    @(negedge clk);
    lk_valid = 1'b0;
    chk(13, {31'd0, rg_ack, rg_rdata}, {31'd0, 1'b1, 32'h8000_0ABC}, "register first");
    chk(11, {63'd0, lk_done}, 64'd0, "lookup not yet done");
    @(negedge clk);
    chk(3, {61'd0, lk_done, lk_hit, lk_owned}, 64'd6, "stalled lookup result");

    // R11 register access beats a fill; the fill lands afterwards
    @(negedge clk);
    fill_en = 1'b1; fill_addr = 32'h1FFE_0060; fill_valid = 1'b1; fill_owned = 1'b1;
    rg_req = 1'b1; rg_we = 1'b1; rg_addr = 32'h0100_0060; rg_wdata = 32'h8000_0055;
    #1 chk(11, {62'd0, fill_ready, lk_ready}, 64'd0, "fill stalled by register");
    @(negedge clk);
    rg_req = 1'b0; rg_we = 1'b0;
    @(negedge clk);
    fill_en = 1'b0;
    drive_op(2'd1, 32'h1FFE_0060, 32'h0);
    chk(11, {61'd0, lk_done, lk_hit, lk_owned}, 64'd7, "fill applied after register write");

    // R12 reset invalidates entries written earlier
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(12, {58'd0, lk_done, lk_hit, lk_owned, rg_ack, rg_unimpl, rg_wb}, 64'd0, "outputs in reset");
    rst = 1'b0;
    drive_op(2'd1, 32'h1578_0080, 32'h0);
    chk(12, {61'd0, lk_done, lk_hit, lk_owned}, 64'd4, "miss after reset");
    drive_op(2'd3, 32'h0100_0080, 32'h0);
    chk(12, {32'd0, rg_rdata}, {32'd0, 32'h0000_0ABC}, "valid cleared by reset");

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule